// File: doc/BRIEF.md
# Output-Channel-Parallel Convolution Engine

This block computes the first convolution layer of a small handwritten-digit classifier. It reads a single-channel 28x28 image from an on-chip memory outside the block and filters it with six 5x5 kernels, using stride 1 and no padding. The result is a 24x24 feature map for each of the six channels. In every step of the multiply-accumulate phase the block fetches one image pixel and multiplies it by the weight at the same position in all six kernels at once. Six lanes of multiply, rescale and accumulate work side by side, so the six kernels share each pixel fetch. A new pixel is accepted on every cycle.

When every position has been accumulated, a second sweep over the 576 output positions adds each channel's bias to all six channels in parallel. All values are 16-bit two's complement fixed point with 8 fractional bits. The word width, the fractional width, the image size, the kernel size and the channel count are parameters. Software loads the kernels and biases through a load port while the engine is idle. It pulses `start` and waits for `done`. It then reads the feature map through a combinational read port.

The controller has five states:
- IDLE: waits for `start`.
- MAC: issues one pixel address per cycle for 14,400 cycles.
- DRAIN: waits one cycle while the last accumulated position is written.
- BIAS: updates one position per cycle for 576 cycles.
- FINISH: raises `done` for one cycle.

The transitions are:
- IDLE to MAC when `start` is high.
- MAC to DRAIN after the last tap of the last position.
- DRAIN to BIAS unconditionally.
- BIAS to FINISH after position 575.
- FINISH to IDLE unconditionally.

Top module: `conv6_engine`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: A `start` sampled high while idle makes `busy` high from the next cycle for exactly 14,978 cycles: 14,400 MAC, 1 DRAIN, 576 BIAS and 1 FINISH.
- R3: `done` is high for exactly one cycle, which is the last busy cycle and follows the final bias write. The complete feature map can be read from that cycle on.
- R4: In the k-th MAC cycle (k = 0..14399), `pix_addr` equals (oy+ky)*28 + ox + kx. The terms are oy = k/600, ox = (k/25)%24, ky = (k%25)/5 and kx = k%5, so output row is the outermost loop and kernel column the innermost. `pix_data` must hold that pixel one cycle after its address.
- R5: Each product is formed as (pixel * weight) shifted arithmetically right by 8 bits, then saturated to [-32768, 32767].
- R6: For each output position, each channel starts from zero and adds its 25 rescaled products in tap order with a saturating 16-bit add. Nothing carries over from other positions or from earlier runs.
- R7: In the bias sweep, each stored value is replaced by the saturated sum of that value and its channel's bias.
- R8: A load with `wld_en` high writes `wld_data` as follows: to the weight of channel c at kernel row ky and column kx when `wld_addr` = c*25 + ky*5 + kx, and to the bias of channel c when `wld_addr` = 150 + c. Loads made while `busy` is high are ignored.
- R9: A `start` pulse received while `busy` is high is ignored. The run in progress keeps its timing and its results.
- R10: `rd_data` returns, combinationally, the value of channel `rd_ch` at output position `rd_pos` = oy*24 + ox. If `rd_pos` > 575 or `rd_ch` > 5, it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a layer computation (ignored while busy) |
| busy | output | 1 | High while a computation is in progress |
| done | output | 1 | One-cycle pulse when the feature map is complete |
| pix_addr | output | 10 | Image memory address, row-major |
| pix_data | input | 16 | Pixel from image memory, one cycle after its address |
| wld_en | input | 1 | Coefficient load strobe |
| wld_addr | input | 8 | Coefficient index (weights 0..149, biases 150..155) |
| wld_data | input | 16 | Coefficient value, Q8.8 |
| rd_pos | input | 10 | Output position to read |
| rd_ch | input | 3 | Output channel to read |
| rd_data | output | 16 | Feature-map value, Q8.8 |

## Verification
The assertions assume that the image memory answers with exactly one cycle of latency. They also assume that `start`, `wld_en` and the read selects are settled around the sampling edge. The bench meets these assumptions by latching `pix_addr` at the falling edge and returning the addressed pixel on the next rising edge. It changes every input only at falling edges. Coefficients are loaded while the engine is idle, except in one deliberate case that checks R8. In that case, and in the repeated `start` pulses that check R9, the behavioural model keeps its original coefficients and timing.

// File: rtl/conv6_pkg.sv
package conv6_pkg;

    // Controller states of the convolution engine
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MAC,
        ST_DRAIN,
        ST_BIAS,
        ST_FINISH
    } seq_state_t;

endpackage

// File: rtl/conv6_seq.sv
module conv6_seq
    import conv6_pkg::*;
#(
    parameter int IMG = 28,
    parameter int KS  = 5,
    localparam int OUTD = IMG - KS + 1,
    localparam int AW   = $clog2(IMG * IMG),
    localparam int TW   = $clog2(KS * KS),
    localparam int PW   = $clog2(OUTD * OUTD),
    localparam int OW   = $clog2(OUTD),
    localparam int KW   = $clog2(KS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          accept,
    output logic          mac_issue,
    output logic [AW-1:0] pix_addr,
    output logic [TW-1:0] tap,
    output logic [PW-1:0] pos,
    output logic          bias_en,
    output logic [PW-1:0] bias_pos
);

    seq_state_t state_q, state_d;

    logic [OW-1:0] oy_q, ox_q;
    logic [KW-1:0] ky_q, kx_q;
    logic [PW-1:0] bp_q;

    logic kx_last, ky_last, ox_last, oy_last, mac_last, bias_last;

    assign kx_last   = (int'(kx_q) == KS - 1);
    assign ky_last   = (int'(ky_q) == KS - 1);
    assign ox_last   = (int'(ox_q) == OUTD - 1);
    assign oy_last   = (int'(oy_q) == OUTD - 1);
    assign mac_last  = kx_last && ky_last && ox_last && oy_last;
    assign bias_last = (int'(bp_q) == OUTD * OUTD - 1);
    assign accept    = (state_q == ST_IDLE) && start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)     state_d = ST_MAC;
            ST_MAC:    if (mac_last)  state_d = ST_DRAIN;
            ST_DRAIN:                 state_d = ST_BIAS;
            ST_BIAS:   if (bias_last) state_d = ST_FINISH;
            ST_FINISH:                state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // loop counters: output row, output column, kernel row, kernel column
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oy_q <= '0;
            ox_q <= '0;
            ky_q <= '0;
            kx_q <= '0;
            bp_q <= '0;
        end else if (accept) begin
            oy_q <= '0;
            ox_q <= '0;
            ky_q <= '0;
            kx_q <= '0;
            bp_q <= '0;
        end else if (state_q == ST_MAC) begin
            if (!kx_last) begin
                kx_q <= kx_q + 1'b1;
            end else begin
                kx_q <= '0;
                if (!ky_last) begin
                    ky_q <= ky_q + 1'b1;
                end else begin
                    ky_q <= '0;
                    if (!ox_last) begin
                        ox_q <= ox_q + 1'b1;
                    end else begin
                        ox_q <= '0;
                        if (!oy_last) begin
                            oy_q <= oy_q + 1'b1;
                        end
                    end
                end
            end
        end else if (state_q == ST_BIAS) begin
            if (!bias_last) begin
                bp_q <= bp_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
        mac_issue = (state_q == ST_MAC);
        bias_en   = (state_q == ST_BIAS);
        bias_pos  = bp_q;
        pix_addr  = AW'((int'(oy_q) + int'(ky_q)) * IMG + int'(ox_q) + int'(kx_q));
        tap       = TW'(int'(ky_q) * KS + int'(kx_q));
        pos       = PW'(int'(oy_q) * OUTD + int'(ox_q));
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    pix_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mac_issue |-> (int'(pix_addr) < IMG * IMG));

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_MAC) |=> (state_q != ST_MAC));

    // R2
    drain_to_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |=> (state_q == ST_BIAS));

endmodule

// File: rtl/conv6_coef.sv
module conv6_coef #(
    parameter int DW   = 16,
    parameter int NCH  = 6,
    parameter int TAPS = 25,
    localparam int LAW = $clog2(NCH * TAPS + NCH),
    localparam int TW  = $clog2(TAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lock,
    input  logic                     ld_en,
    input  logic [LAW-1:0]           ld_addr,
    input  logic [DW-1:0]            ld_data,
    input  logic [TW-1:0]            rd_tap,
    output logic [NCH-1:0][DW-1:0]   w_lane,
    output logic [NCH-1:0][DW-1:0]   b_lane
);

    logic [NCH-1:0][TAPS-1:0][DW-1:0] wq;
    logic [NCH-1:0][DW-1:0]           bq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wq <= '0;
            bq <= '0;
        end else if (ld_en && !lock) begin
            for (int c = 0; c < NCH; c++) begin
                for (int t = 0; t < TAPS; t++) begin
                    if (int'(ld_addr) == c * TAPS + t) begin
                        wq[c][t] <= ld_data;
                    end
                end
                if (int'(ld_addr) == NCH * TAPS + c) begin
                    bq[c] <= ld_data;
                end
            end
        end
    end

    // one weight per channel at the same kernel position
    always_comb begin
        w_lane = '0;
        for (int c = 0; c < NCH; c++) begin
            for (int t = 0; t < TAPS; t++) begin
                if (int'(rd_tap) == t) begin
                    w_lane[c] = wq[c][t];
                end
            end
        end
    end

    assign b_lane = bq;

    // R8
    coef_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(wq) && $stable(bq)));

endmodule

// File: rtl/conv6_mac.sv
module conv6_mac #(
    parameter int DW   = 16,
    parameter int FRAC = 8,
    parameter int NCH  = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   in_valid,
    input  logic                   in_first,
    input  logic [DW-1:0]          pix,
    input  logic [NCH-1:0][DW-1:0] w_lane,
    output logic [NCH-1:0][DW-1:0] sum_next
);

    localparam int XW = 2 * DW + 1;
    localparam logic signed [XW-1:0] HI = XW'((1 <<< (DW - 1)) - 1);
    localparam logic signed [XW-1:0] LO = -HI - XW'(1);

    function automatic logic [DW-1:0] sat_dw(input logic signed [XW-1:0] v);
        if (v > HI) begin
            return HI[DW-1:0];
        end else if (v < LO) begin
            return LO[DW-1:0];
        end else begin
            return v[DW-1:0];
        end
    endfunction

    logic [NCH-1:0][DW-1:0] acc_q;

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        logic signed [2*DW-1:0] prod;
        logic signed [DW-1:0]   prod_sat;
        logic signed [DW-1:0]   base;

        always_comb begin
            prod        = $signed(pix) * $signed(w_lane[c]);
            prod_sat    = $signed(sat_dw(XW'(prod >>> FRAC)));
            base        = in_first ? '0 : $signed(acc_q[c]);
            sum_next[c] = sat_dw(XW'(base) + XW'(prod_sat));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (in_valid) begin
            acc_q <= sum_next;
        end
    end

    // R6
    acc_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_q == '0));

endmodule

// File: rtl/conv6_fmap.sv
module conv6_fmap #(
    parameter int DW   = 16,
    parameter int NCH  = 6,
    parameter int NPOS = 576,
    localparam int PW  = $clog2(NPOS),
    localparam int CW  = $clog2(NCH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [PW-1:0]          wr_pos,
    input  logic [NCH-1:0][DW-1:0] wr_data,
    input  logic                   bias_en,
    input  logic [PW-1:0]          bias_pos,
    input  logic [NCH-1:0][DW-1:0] b_lane,
    input  logic [PW-1:0]          rd_pos,
    input  logic [CW-1:0]          rd_ch,
    output logic [DW-1:0]          rd_data
);

    localparam int XW = DW + 1;
    localparam logic signed [XW-1:0] HI = XW'((1 <<< (DW - 1)) - 1);
    localparam logic signed [XW-1:0] LO = -HI - XW'(1);

    function automatic logic [DW-1:0] sat_dw(input logic signed [XW-1:0] v);
        if (v > HI) begin
            return HI[DW-1:0];
        end else if (v < LO) begin
            return LO[DW-1:0];
        end else begin
            return v[DW-1:0];
        end
    endfunction

    logic [NCH-1:0][DW-1:0] mem [NPOS];
    logic [NCH-1:0][DW-1:0] cur;
    logic [NCH-1:0][DW-1:0] biased;

    always_comb begin
        cur = '0;
        if (int'(bias_pos) < NPOS) begin
            cur = mem[bias_pos];
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_bias
        always_comb begin
            biased[c] = sat_dw(XW'($signed(cur[c])) + XW'($signed(b_lane[c])));
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_pos] <= wr_data;
        end else if (bias_en) begin
            mem[bias_pos] <= biased;
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_pos) < NPOS && int'(rd_ch) < NCH) begin
            rd_data = mem[rd_pos][rd_ch];
        end
    end

    // R7
    write_port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && bias_en));

endmodule

// File: rtl/conv6_engine.sv
module conv6_engine #(
    parameter int DW   = 16,
    parameter int FRAC = 8,
    parameter int IMG  = 28,
    parameter int KS   = 5,
    parameter int NCH  = 6,
    localparam int OUTD = IMG - KS + 1,
    localparam int TAPS = KS * KS,
    localparam int NPOS = OUTD * OUTD,
    localparam int AW   = $clog2(IMG * IMG),
    localparam int TW   = $clog2(TAPS),
    localparam int PW   = $clog2(NPOS),
    localparam int LAW  = $clog2(NCH * TAPS + NCH),
    localparam int CW   = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           busy,
    output logic           done,
    output logic [AW-1:0]  pix_addr,
    input  logic [DW-1:0]  pix_data,
    input  logic           wld_en,
    input  logic [LAW-1:0] wld_addr,
    input  logic [DW-1:0]  wld_data,
    input  logic [PW-1:0]  rd_pos,
    input  logic [CW-1:0]  rd_ch,
    output logic [DW-1:0]  rd_data
);

    logic                   accept;
    logic                   mac_issue;
    logic [TW-1:0]          tap;
    logic [PW-1:0]          pos;
    logic                   bias_en;
    logic [PW-1:0]          bias_pos;
    logic [NCH-1:0][DW-1:0] w_lane;
    logic [NCH-1:0][DW-1:0] b_lane;
    logic [NCH-1:0][DW-1:0] sum_next;

    // stage aligned with the pixel returned by memory
    logic          s1_valid;
    logic [TW-1:0] s1_tap;
    logic [PW-1:0] s1_pos;
    logic          s1_first;
    logic          s1_last;

    conv6_seq #(.IMG(IMG), .KS(KS)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .busy      (busy),
        .done      (done),
        .accept    (accept),
        .mac_issue (mac_issue),
        .pix_addr  (pix_addr),
        .tap       (tap),
        .pos       (pos),
        .bias_en   (bias_en),
        .bias_pos  (bias_pos)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_tap   <= '0;
            s1_pos   <= '0;
        end else begin
            s1_valid <= mac_issue;
            s1_tap   <= tap;
            s1_pos   <= pos;
        end
    end

    assign s1_first = (int'(s1_tap) == 0);
    assign s1_last  = (int'(s1_tap) == TAPS - 1);

    conv6_coef #(.DW(DW), .NCH(NCH), .TAPS(TAPS)) i_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock    (busy),
        .ld_en   (wld_en),
        .ld_addr (wld_addr),
        .ld_data (wld_data),
        .rd_tap  (s1_tap),
        .w_lane  (w_lane),
        .b_lane  (b_lane)
    );

    conv6_mac #(.DW(DW), .FRAC(FRAC), .NCH(NCH)) i_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .in_valid (s1_valid),
        .in_first (s1_first),
        .pix      (pix_data),
        .w_lane   (w_lane),
        .sum_next (sum_next)
    );

    conv6_fmap #(.DW(DW), .NCH(NCH), .NPOS(NPOS)) i_fmap (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (s1_valid && s1_last),
        .wr_pos   (s1_pos),
        .wr_data  (sum_next),
        .bias_en  (bias_en),
        .bias_pos (bias_pos),
        .b_lane   (b_lane),
        .rd_pos   (rd_pos),
        .rd_ch    (rd_ch),
        .rd_data  (rd_data)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !done));

endmodule

// File: tb/test_conv6_engine.sv
module test_conv6_engine;

    localparam int DW        = 16;
    localparam int FRAC      = 8;
    localparam int IMG       = 28;
    localparam int KS        = 5;
    localparam int NCH       = 6;
    localparam int OUTD      = IMG - KS + 1;
    localparam int TAPS      = KS * KS;
    localparam int NPOS      = OUTD * OUTD;
    localparam int MAC_STEPS = NPOS * TAPS;
    localparam int TOTAL     = MAC_STEPS + 1 + NPOS + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done;
    logic [9:0]  pix_addr;
    logic [15:0] pix_data = '0;
    logic        wld_en = 1'b0;
    logic [7:0]  wld_addr = '0;
    logic [15:0] wld_data = '0;
    logic [9:0]  rd_pos = '0;
    logic [2:0]  rd_ch = '0;
    logic [15:0] rd_data;

    int img [IMG*IMG];
    int wt  [NCH][TAPS];
    int bs  [NCH];

    int checks = 0;
    int fails  = 0;
    int rem    = 0;
    bit finished = 1'b0;
    logic [9:0] addr_lat = '0;

    always #2 clk = ~clk;

    conv6_engine i_conv6_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .busy     (busy),
        .done     (done),
        .pix_addr (pix_addr),
        .pix_data (pix_data),
        .wld_en   (wld_en),
        .wld_addr (wld_addr),
        .wld_data (wld_data),
        .rd_pos   (rd_pos),
        .rd_ch    (rd_ch),
        .rd_data  (rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // image memory, one cycle latency
    always @(negedge clk) addr_lat <= pix_addr;
    always @(posedge clk) pix_data <= (int'(addr_lat) < IMG*IMG) ? 16'(img[addr_lat]) : 16'h0;

    // cycle model of the run timing
    always @(posedge clk) begin
        if (!rst_n) rem <= 0;
        else if (rem == 0 && start) rem <= TOTAL;
        else if (rem > 0) rem <= rem - 1;
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy === (rem > 0), "R2 busy", int'(busy), int'(rem > 0));
            chk(done === (rem == 1), "R3 done", int'(done), int'(rem == 1));
            if (rem > 0 && TOTAL - rem < MAC_STEPS) begin
                int k, ea;
                k  = TOTAL - rem;
                ea = ((k / 600) + (k % 25) / 5) * IMG + ((k / 25) % OUTD) + (k % 5);
                chk(int'(pix_addr) == ea, "R4 pix_addr", int'(pix_addr), ea);
            end
        end
    end

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int ref_out(input int oy, input int ox, input int c);
        int acc;
        acc = 0;
        for (int ky = 0; ky < KS; ky++) begin
            for (int kx = 0; kx < KS; kx++) begin
                int p;
                p   = img[(oy + ky) * IMG + ox + kx] * wt[c][ky * KS + kx];
                p   = sat16(p >>> FRAC);
                acc = sat16(acc + p);
            end
        end
        return sat16(acc + bs[c]);
    endfunction

    task automatic load(input int addr, input int val);
        @(negedge clk);
        wld_en   = 1'b1;
        wld_addr = 8'(addr);
        wld_data = 16'(val);
        @(negedge clk);
        wld_en   = 1'b0;
    endtask

    task automatic load_all();
        for (int c = 0; c < NCH; c++) begin
            for (int t = 0; t < TAPS; t++) load(c * TAPS + t, wt[c][t]);
            load(NCH * TAPS + c, bs[c]);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (done !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    // R5 R6 R7 R10: compare every output value
    task automatic check_all(input string tag);
        for (int p = 0; p < NPOS; p++) begin
            for (int c = 0; c < NCH; c++) begin
                int e;
                rd_pos = 10'(p);
                rd_ch  = 3'(c);
                #1;
                e = ref_out(p / OUTD, p % OUTD, c);
                chk(int'($signed(rd_data)) == e, tag, int'($signed(rd_data)), e);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy === 1'b0, "R1 busy", int'(busy), 0);
        chk(done === 1'b0, "R1 done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1 idle after reset", int'(busy), 0);

        // pattern 1: moderate mixed-sign values
        for (int i = 0; i < IMG*IMG; i++) img[i] = ((i * 37) % 512) - 256;
        for (int c = 0; c < NCH; c++) begin
            for (int t = 0; t < TAPS; t++) wt[c][t] = ((c * 31 + t * 7) % 128) - 64;
            bs[c] = c * 100 - 250;
        end
        load_all();   // R8 address map
        pulse_start();
        wait_done();
        check_all("R6 R7 pattern1");

        // pattern 2: saturation of products, sums and bias
        for (int i = 0; i < IMG*IMG; i++) img[i] = (i % 2 == 0) ? 32767 : 20000;
        for (int c = 0; c < NCH; c++) begin
            for (int t = 0; t < TAPS; t++)
                wt[c][t] = (c == 5) ? 3 : ((c % 2 == 0) ? 32767 : -32768);
            bs[c] = (c % 2 == 0) ? 32767 : -32768;
        end
        load_all();
        pulse_start();
        wait_done();
        check_all("R5 saturation pattern2");

        // pattern 3: ramp image, loads and restarts while busy
        for (int i = 0; i < IMG*IMG; i++) img[i] = i * 40 - 15000;
        for (int c = 0; c < NCH; c++) begin
            for (int t = 0; t < TAPS; t++) wt[c][t] = t - 12 + c * 2;
            bs[c] = 0;
        end
        load_all();
        pulse_start();
        repeat (100) @(negedge clk);
        load(0, 16'h1234);          // R8: ignored while busy
        load(NCH * TAPS + 2, 999);  // R8: ignored while busy
        pulse_start();              // R9: ignored in MAC
        repeat (14500) @(negedge clk);
        pulse_start();              // R9: ignored in BIAS
        wait_done();
        check_all("R8 R9 pattern3");

        // R10: out-of-range selects read zero
        rd_pos = 10'd600; rd_ch = 3'd0; #1;
        chk(rd_data == 16'h0, "R10 pos range", int'(rd_data), 0);
        rd_pos = 10'd5; rd_ch = 3'd6; #1;
        chk(rd_data == 16'h0, "R10 ch range", int'(rd_data), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule